// File: doc/BRIEF.md
# Interval Timer Bus Front End

This block sits between a processor's 8-bit peripheral bus and three independent down-counting timer channels. It decodes programming words, assembles 16-bit reload values from byte-wide writes, and returns live or frozen counts one byte at a time. The counting engines are outside this block. Each channel receives its operating mode, a decimal-count flag, the assembled reload value with a load strobe, and a strobe when it has been reprogrammed. Each channel returns its live count.

Bus accesses act on strobe edges. A write takes effect on the first clock where select and write are both high. A read presents data while select and read are high, and it advances that channel's byte pointer when the read strobe ends. Each channel keeps its own write-byte pointer, read-byte pointer and snapshot latch, so that interleaved traffic to different channels does not interfere.

A snapshot command copies a channel's live count into a holding register. Reads then return the held value until it has been fully consumed, while the channel keeps counting.

Top module: `tmr_bus_front`

## Requirements
- R1: A write to address 3 is a programming word. Bits 7:6 pick the channel (0 to 2) and bits 5:4 the byte access code. When the access code is not 00, bits 3:1 become that channel's mode and bit 0 its decimal flag. Exactly that channel's mode-set strobe pulses for one cycle on the clock after the write.
- R2: With access code 01, one write to the channel's address (0 to 2) loads the count {8'h00, data} and pulses that channel's load strobe for one cycle.
- R3: With access code 10, one write loads the count {data, 8'h00} and pulses the load strobe.
- R4: With access code 11, the first write holds the low byte and produces no load. The second write loads {data, held low byte} and pulses the load strobe.
- R5: Reads return bytes of the live count. Code 01 always returns the low byte and code 10 always the high byte. Code 11 alternates, starting with the low byte.
- R6: A programming word with access code 00 is a snapshot command. It captures the live count and produces no mode-set strobe. Reads return the captured value, one read for codes 01/10 and two reads for code 11, even if the live count changes. After that, reads return the live count again.
- R7: A snapshot command issued while an earlier snapshot is not yet fully read is ignored, and the earlier value is kept.
- R8: A programming word with a non-00 access code resets that channel's write and read byte pointers and discards any pending snapshot.
- R9: Read data is driven (the output enable is high) only while select and read are both high. At other times the enable is low and the data output is zero. A read of address 3 returns zero.
- R10: Reads never pulse a load strobe and never change the count outputs.
- R11: After reset, all modes, decimal flags and counts are zero, no strobe is active and read data is not driven.
- R12: A programming word with channel select 3 changes no channel state and produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Chip select, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_addr | input | 2 | 0..2 channel data, 3 programming word |
| bus_din | input | 8 | Write data |
| bus_dout | output | 8 | Read data |
| bus_dout_en | output | 1 | Read data drive enable for the pad tri-state |
| ch_live | input | 48 | Live counts from channels, 16 bits each, channel 0 lowest |
| ch_count | output | 48 | Assembled reload values, 16 bits each |
| ch_load | output | 3 | One-cycle reload strobe per channel |
| ch_mode | output | 9 | Mode, 3 bits per channel |
| ch_bcd | output | 3 | Decimal-count flag per channel |
| ch_mode_set | output | 3 | One-cycle reprogramming strobe per channel |

## Verification
The hardest state to reach is a half-consumed snapshot in word access mode: a snapshot has been taken, one byte has been read, and the live count has changed since. A second snapshot command or a reprogramming word then arrives. The stimulus builds this deliberately. It changes the live count between the snapshot and each read, issues the competing command between the two reads, and confirms from the returned bytes that the right value was either kept or discarded. The write-side counterpart is a reprogramming word inserted between the two halves of a word write. This is then followed by a fresh pair whose load must take both new bytes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BW = 8;
  localparam int CW = 2 * BW;

  typedef enum logic [1:0] {
    ACC_SNAP = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_WORD = 2'b11
  } acc_e;

  // Build a full count from the byte just written and the held low byte.
  function automatic logic [CW-1:0] tmr_join(acc_e a, logic [BW-1:0] d,
                                             logic [BW-1:0] held);
    case (a)
      ACC_LO:  tmr_join = {{BW{1'b0}}, d};
      ACC_HI:  tmr_join = {d, {BW{1'b0}}};
      default: tmr_join = {d, held};
    endcase
  endfunction

  // Choose which byte of a count a read returns.
  function automatic logic [BW-1:0] tmr_pick(acc_e a, logic hi_ptr,
                                             logic [CW-1:0] v);
    case (a)
      ACC_HI:   tmr_pick = v[CW-1:BW];
      ACC_WORD: tmr_pick = hi_ptr ? v[CW-1:BW] : v[BW-1:0];
      default:  tmr_pick = v[BW-1:0];
    endcase
  endfunction
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sel,
  input  logic           rd,
  input  logic           wr,
  input  logic [1:0]     addr,
  output logic           wr_edge,
  output logic           ctl_wr,
  output logic [NCH-1:0] cnt_wr,
  output logic [NCH-1:0] rd_done
);
  logic wr_q, rd_q;
  logic [1:0] rd_addr_q;
  logic wr_act, rd_act, rd_end;

  assign wr_act  = sel && wr;
  assign rd_act  = sel && rd;
  assign wr_edge = wr_act && !wr_q;
  assign rd_end  = rd_q && !rd_act;
  assign ctl_wr  = wr_edge && (addr == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      rd_addr_q <= 2'd0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (rd_act) rd_addr_q <= addr;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign cnt_wr[i]  = wr_edge && (addr == 2'(i));
    assign rd_done[i] = rd_end && (rd_addr_q == 2'(i));
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          cnt_wr,
  input  logic          rd_done,
  input  logic [BW-1:0] din,
  input  logic [CW-1:0] live,
  output logic [2:0]    mode,
  output logic          bcd,
  output logic [CW-1:0] count,
  output logic          load,
  output logic          mode_set,
  output logic [BW-1:0] rd_byte,
  output logic          snap_busy
);
  acc_e          acc;
  logic          wr_hi, rd_hi;
  logic [BW-1:0] held;
  logic [CW-1:0] snap;
  logic          ctl_hit;
  acc_e          new_acc;

  assign ctl_hit   = ctl_wr && (din[7:6] == 2'(IDX));
  assign new_acc   = acc_e'(din[5:4]);
  assign rd_byte   = tmr_pick(acc, rd_hi, snap_busy ? snap : live);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= ACC_SNAP;
      mode      <= 3'd0;
      bcd       <= 1'b0;
      count     <= '0;
      load      <= 1'b0;
      mode_set  <= 1'b0;
      wr_hi     <= 1'b0;
      rd_hi     <= 1'b0;
      held      <= '0;
      snap      <= '0;
      snap_busy <= 1'b0;
    end else begin
      load     <= 1'b0;
      mode_set <= 1'b0;
      // end of a read: advance pointer, consume snapshot
      if (rd_done) begin
        if (acc == ACC_WORD) rd_hi <= !rd_hi;
        if (snap_busy && (acc != ACC_WORD || rd_hi)) snap_busy <= 1'b0;
      end
      // programming word and count writes override the read bookkeeping
      if (ctl_hit) begin
        if (new_acc == ACC_SNAP) begin
          if (!snap_busy) begin
            snap      <= live;
            snap_busy <= 1'b1;
          end
        end else begin
          acc       <= new_acc;
          mode      <= din[3:1];
          bcd       <= din[0];
          wr_hi     <= 1'b0;
          rd_hi     <= 1'b0;
          snap_busy <= 1'b0;
          mode_set  <= 1'b1;
        end
      end else if (cnt_wr && acc != ACC_SNAP) begin
        if (acc == ACC_WORD && !wr_hi) begin
          held  <= din;
          wr_hi <= 1'b1;
        end else begin
          count <= tmr_join(acc, din, held);
          load  <= 1'b1;
          wr_hi <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              sel,
  input  logic              rd,
  input  logic [1:0]        addr,
  input  logic [NCH*BW-1:0] bytes,
  output logic [BW-1:0]     dout,
  output logic              dout_en
);
  assign dout_en = sel && rd;

  always_comb begin
    dout = '0;
    for (int i = 0; i < NCH; i++) begin
      if (dout_en && addr == 2'(i)) dout = bytes[i*BW +: BW];
    end
  end
endmodule

// File: rtl/tmr_bus_front.sv
module tmr_bus_front
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [BW-1:0]     bus_din,
  output logic [BW-1:0]     bus_dout,
  output logic              bus_dout_en,
  input  logic [NCH*CW-1:0] ch_live,
  output logic [NCH*CW-1:0] ch_count,
  output logic [NCH-1:0]    ch_load,
  output logic [NCH*3-1:0]  ch_mode,
  output logic [NCH-1:0]    ch_bcd,
  output logic [NCH-1:0]    ch_mode_set
);
  logic              wr_edge;
  logic              ctl_wr;
  logic [NCH-1:0]    cnt_wr;
  logic [NCH-1:0]    rd_done;
  logic [NCH-1:0]    snap_busy;
  logic [NCH*BW-1:0] rd_bytes;

  tmr_bus_decode #(.NCH(NCH)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (bus_sel),
    .rd      (bus_rd),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wr_edge (wr_edge),
    .ctl_wr  (ctl_wr),
    .cnt_wr  (cnt_wr),
    .rd_done (rd_done)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_chan_regs #(.IDX(i)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .cnt_wr    (cnt_wr[i]),
      .rd_done   (rd_done[i]),
      .din       (bus_din),
      .live      (ch_live[i*CW +: CW]),
      .mode      (ch_mode[i*3 +: 3]),
      .bcd       (ch_bcd[i]),
      .count     (ch_count[i*CW +: CW]),
      .load      (ch_load[i]),
      .mode_set  (ch_mode_set[i]),
      .rd_byte   (rd_bytes[i*BW +: BW]),
      .snap_busy (snap_busy[i])
    );
  end

  tmr_read_mux #(.NCH(NCH)) u_mux (
    .sel     (bus_sel),
    .rd      (bus_rd),
    .addr    (bus_addr),
    .bytes   (rd_bytes),
    .dout    (bus_dout),
    .dout_en (bus_dout_en)
  );
endmodule

// File: rtl/tmr_bus_front_chk.sv
module tmr_bus_front_chk
  import tmr_pkg::*;
#(
  parameter int NCH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic [BW-1:0]     bus_din,
  input logic [BW-1:0]     bus_dout,
  input logic              bus_dout_en,
  input logic [NCH*CW-1:0] ch_count,
  input logic [NCH-1:0]    ch_load,
  input logic [NCH-1:0]    ch_mode_set,
  input logic              wr_edge
);
  // R1: a reprogramming strobe follows a non-snapshot programming word
  p_modeset_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_mode_set != '0) |-> $past(wr_edge && bus_addr == 2'd3 && bus_din[5:4] != 2'b00));

  // R1: at most one channel reprogrammed per write
  p_modeset_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_mode_set));

  // R2: a load follows a write to a channel data address
  p_load_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_load != '0) |-> $past(wr_edge && bus_addr != 2'd3));

  // R4: at most one channel loads per cycle
  p_load_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load));

  // R9: data not driven outside an active read
  p_bus_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_rd) |-> (!bus_dout_en && bus_dout == '0));

  // R10: counts only move together with a load strobe
  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_load == '0) |-> $stable(ch_count));
endmodule

bind tmr_bus_front tmr_bus_front_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_rd      (bus_rd),
  .bus_addr    (bus_addr),
  .bus_din     (bus_din),
  .bus_dout    (bus_dout),
  .bus_dout_en (bus_dout_en),
  .ch_count    (ch_count),
  .ch_load     (ch_load),
  .ch_mode_set (ch_mode_set),
  .wr_edge     (wr_edge)
);

// File: tb/tmr_bus_front_bench.sv
module tmr_bus_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_din = 8'd0;
  logic [7:0]  bus_dout;
  logic        bus_dout_en;
  logic [47:0] ch_live = 48'd0;
  logic [47:0] ch_count;
  logic [2:0]  ch_load;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd;
  logic [2:0]  ch_mode_set;

  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] cap_load, cap_ms;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = !clk;

  tmr_bus_front u_tmr_bus_front (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .ch_live(ch_live),
    .ch_count(ch_count), .ch_load(ch_load), .ch_mode(ch_mode),
    .ch_bcd(ch_bcd), .ch_mode_set(ch_mode_set)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_din = d;
    @(negedge clk);
    #1;
    cap_load = ch_load;
    cap_ms   = ch_mode_set;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  // driver: push the expected byte, then perform the read
  task automatic bus_read(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compare every driven byte with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        check("R9 enable", {31'd0, bus_dout_en}, {31'd0, bus_sel && bus_rd});
        if (bus_dout_en) begin
          check("R10 no load on read", {29'd0, ch_load}, 32'd0);
          if (exp_q.size() == 0) begin
            check("scoreboard underflow", 32'd1, 32'd0);
          end else begin
            string t;
            logic [7:0] e;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {24'd0, bus_dout}, {24'd0, e});
          end
        end else begin
          check("R9 idle data", {24'd0, bus_dout}, 32'd0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    ch_live = {16'h0F0E, 16'hABCD, 16'h1234};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    check("R11 mode", {23'd0, ch_mode}, 32'd0);
    check("R11 bcd", {29'd0, ch_bcd}, 32'd0);
    check("R11 count lo", ch_count[31:0], 32'd0);
    check("R11 strobes", {26'd0, ch_load, ch_mode_set}, 32'd0);
    check("R11 bus", {23'd0, bus_dout_en, bus_dout}, 32'd0);

    // R1: ch0, word access, mode 2, decimal
    bus_write(2'd3, 8'b00_11_010_1);
    check("R1 mode_set", {29'd0, cap_ms}, 32'd1);
    check("R1 mode", {29'd0, ch_mode[2:0]}, 32'd2);
    check("R1 bcd", {29'd0, ch_bcd}, 32'd1);
    @(negedge clk);
    check("R1 strobe width", {29'd0, ch_mode_set}, 32'd0);

    // R4 two-byte write
    bus_write(2'd0, 8'h78);
    check("R4 no load on low", {29'd0, cap_load}, 32'd0);
    bus_write(2'd0, 8'h56);
    check("R4 load", {29'd0, cap_load}, 32'd1);
    check("R4 count", {16'd0, ch_count[15:0]}, 32'h5678);

    // R5 alternating live reads, R10 count untouched
    bus_read(2'd0, 8'h34, "R5 lo");
    bus_read(2'd0, 8'h12, "R5 hi");
    ch_live[15:0] = 16'h2468;
    bus_read(2'd0, 8'h68, "R5 live lo");
    bus_read(2'd0, 8'h24, "R5 live hi");
    check("R10 count after reads", {16'd0, ch_count[15:0]}, 32'h5678);

    // R2 low-only on ch1
    bus_write(2'd3, 8'b01_01_011_0);
    check("R1 ch1 mode_set", {29'd0, cap_ms}, 32'd2);
    bus_write(2'd1, 8'd200);
    check("R2 load", {29'd0, cap_load}, 32'd2);
    check("R2 count", {16'd0, ch_count[31:16]}, 32'h00C8);
    bus_read(2'd1, 8'hCD, "R5 lo-only 1");
    bus_read(2'd1, 8'hCD, "R5 lo-only 2");

    // R3 high-only on ch2
    bus_write(2'd3, 8'b10_10_100_0);
    check("R1 ch2 mode", {29'd0, ch_mode[8:6]}, 32'd4);
    bus_write(2'd2, 8'h07);
    check("R3 load", {29'd0, cap_load}, 32'd4);
    check("R3 count", {16'd0, ch_count[47:32]}, 32'h0700);
    bus_read(2'd2, 8'h0F, "R5 hi-only");

    // R6 snapshot, R7 ignored second snapshot
    ch_live[15:0] = 16'h3141;
    bus_write(2'd3, 8'b00_00_000_0);
    check("R6 no mode_set", {29'd0, cap_ms}, 32'd0);
    check("R6 mode kept", {29'd0, ch_mode[2:0]}, 32'd2);
    ch_live[15:0] = 16'h9999;
    bus_read(2'd0, 8'h41, "R6 frozen lo");
    bus_write(2'd3, 8'b00_00_000_0);
    ch_live[15:0] = 16'h7777;
    bus_read(2'd0, 8'h31, "R7 kept hi");
    bus_read(2'd0, 8'h77, "R6 live again lo");
    bus_read(2'd0, 8'h77, "R6 live again hi");

    // R8 reprogram discards half-read snapshot and resets pointers
    ch_live[15:0] = 16'h5A6B;
    bus_write(2'd3, 8'b00_00_000_0);
    bus_read(2'd0, 8'h6B, "R6 snap lo");
    bus_write(2'd3, 8'b00_11_011_0);
    check("R8 mode", {29'd0, ch_mode[2:0]}, 32'd3);
    check("R8 bcd", {31'd0, ch_bcd[0]}, 32'd0);
    ch_live[15:0] = 16'h1357;
    bus_read(2'd0, 8'h57, "R8 ptr lo");
    bus_read(2'd0, 8'h13, "R8 ptr hi");
    bus_write(2'd0, 8'h11);
    bus_write(2'd3, 8'b00_11_011_0);
    bus_write(2'd0, 8'hAA);
    check("R8 no load after first", {29'd0, cap_load}, 32'd0);
    bus_write(2'd0, 8'hBB);
    check("R8 load", {29'd0, cap_load}, 32'd1);
    check("R8 count", {16'd0, ch_count[15:0]}, 32'hBBAA);

    // R12 channel select 3 ignored
    bus_write(2'd3, 8'b11_01_101_1);
    check("R12 no mode_set", {29'd0, cap_ms}, 32'd0);
    check("R12 modes", {23'd0, ch_mode}, {23'd0, 3'd4, 3'd3, 3'd3});
    check("R12 bcd", {29'd0, ch_bcd}, 32'd0);

    // R9 address 3 reads zero; no drive with select low
    bus_read(2'd3, 8'h00, "R9 addr3");
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 2'd0;
    #1;
    check("R9 no select", {31'd0, bus_dout_en}, 32'd0);
    @(negedge clk);
    bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule